// File: doc/BRIEF.md
# Display Run/Stop and Shadow-Update Controller

This block is the control core of a display engine. Software writes a control word with three action bits: start, stop and update request. It also writes a mode bit, a tearing-effect setup word, an interrupt enable mask and a staged ("shadow") configuration word. The block decides when the staged configuration becomes the active configuration that the rest of the engine uses. It also tracks whether the engine is running and raises events into an interrupt status register.

The block has two modes. In continuous video mode the engine runs frame after frame. An update request made while running is applied at the next frame boundary, which is reported by the `frame_end` pulse. A stop request completes at the next frame boundary in the same way. In command mode the staged configuration is taken only when the engine is started. The engine then waits for a rising edge on the selected tearing-effect input and sends one frame. At the end of that frame it stops by itself and reports done. Register writes use a single-cycle strobe with an address and data. All inputs are assumed synchronous to `clk`.

Top module: `disp_run_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `running`, `frame_busy`, `active_cfg`, `irq_status` and `irq` are all zero, and the interrupt enable mask is zero.
- R2: A write to address 0x004 with bit 0 set (start) while stopped sets `running` and loads `active_cfg` from the staged word, which is written at address 0x030. A start written while already running has no effect.
- R3: In video mode (bit 0 of address 0x008 clear), a write to 0x004 with bit 2 set (update) while running leaves `active_cfg` unchanged until the first `frame_end` after the write cycle. On that frame end, `active_cfg` takes the staged word and status bit 4 (update-done) is set. Staged writes alone never change `active_cfg` while running.
- R4: In video mode, a write to 0x004 with bit 1 set (stop) while running keeps `running` high until the first `frame_end` after the write. On that frame end `running` clears and status bit 0 (done) is set.
- R5: In video mode, every `frame_end` while running sets status bit 5 (vsync). A `frame_end` while stopped sets nothing.
- R6: In video mode, an update request while stopped copies the staged word into `active_cfg` at once and sets no status bit.
- R7: In command mode (bit 0 of 0x008 set), starting loads `active_cfg` from the staged word. Update requests are ignored in command mode: `active_cfg` is unchanged and status bit 4 is not set.
- R8: In command mode after a start, a rising edge of the tearing-effect source begins a frame (`frame_busy` high) and sets status bit 1. The source is `te_pad` when bit 10 of address 0x1F0 is set and `te_int` when it is clear. A `frame_end` before that edge has no effect. A `frame_end` while `frame_busy` is high clears `frame_busy` and `running` and sets status bit 0.
- R9: With bit 8 of 0x1F0 (tearing-effect enable) clear, tearing-effect edges neither start a frame nor set status bit 1.
- R10: A status bit is set by its event whatever the enable mask holds. A `underflow` pulse sets status bit 2. The enable mask is written at 0x1E0. `irq` is high exactly when some status bit and its enable bit are both set.
- R11: Writing a mask to 0x1E4 clears the status bits set in that mask; 0xFF clears all of them. If an event and a clear of the same bit fall in one cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | 32 | Register write data |
| frame_end | input | 1 | Pulse at the end of each frame from the timing logic |
| te_int | input | 1 | Internal tearing-effect signal |
| te_pad | input | 1 | External-pad tearing-effect signal |
| underflow | input | 1 | Pixel underflow error pulse |
| active_cfg | output | CFG_W | Active configuration word |
| running | output | 1 | Engine running |
| frame_busy | output | 1 | Command-mode frame in progress |
| irq_status | output | 8 | Interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block is due one clock edge after the cycle in which its stimulus is presented. This holds for a register write, a `frame_end` pulse, a tearing-effect edge and an underflow pulse alike: a write made in the same cycle as a frame end therefore only counts toward the following frame end. The bench drives each stimulus shortly after a rising edge and holds it for one cycle. It then samples shortly after the next rising edge, so every check lands on the first cycle in which the result must be visible. Deferred effects, such as a pending update or a pending stop, are checked both before and after the `frame_end` that commits them.

// File: rtl/disp_ctrl_pkg.sv
// Shared register addresses, bit positions and event type for the
// display run/stop controller.
package disp_ctrl_pkg;
    localparam int PKG_ADDR_W = 12;
    localparam int ST_W       = 8;

    localparam logic [PKG_ADDR_W-1:0] A_CTRL    = 12'h004;
    localparam logic [PKG_ADDR_W-1:0] A_MODE    = 12'h008;
    localparam logic [PKG_ADDR_W-1:0] A_SHADOW  = 12'h030;
    localparam logic [PKG_ADDR_W-1:0] A_INT_EN  = 12'h1E0;
    localparam logic [PKG_ADDR_W-1:0] A_INT_CLR = 12'h1E4;
    localparam logic [PKG_ADDR_W-1:0] A_TE_CTRL = 12'h1F0;

    localparam int B_START  = 0;
    localparam int B_STOP   = 1;
    localparam int B_UPDATE = 2;
    localparam int B_CMD    = 0;
    localparam int B_TE_EN  = 8;
    localparam int B_TE_PAD = 10;

    localparam int EV_DONE  = 0;
    localparam int EV_TE    = 1;
    localparam int EV_ERR   = 2;
    localparam int EV_UPD   = 4;
    localparam int EV_VSYNC = 5;

    localparam logic [ST_W-1:0] ST_VALID = 8'h37;

    typedef struct packed {
        logic done;
        logic te;
        logic upd;
        logic vsync;
    } seq_evt_t;
endpackage

// File: rtl/disp_reg_if.sv
// Register write decoder. It turns write strobes into one-cycle action
// pulses and holds the mode, tearing-effect setup, interrupt enable and
// staged configuration. Assumes writes are single-cycle strobes.
module disp_reg_if
    import disp_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              start_wr,
    output logic              stop_wr,
    output logic              upd_wr,
    output logic [ST_W-1:0]   clr_mask,
    output logic              cmd_mode,
    output logic              te_en,
    output logic              te_pad_sel,
    output logic [ST_W-1:0]   int_en,
    output logic [CFG_W-1:0]  shadow_cfg
);
    logic hit_ctrl;
    logic hit_clr;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Decode the action pulses of the current write
    always_comb begin
        hit_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        hit_clr  = wr_en && (wr_addr == ADDR_W'(A_INT_CLR));
        start_wr = hit_ctrl && wr_data[B_START];
        stop_wr  = hit_ctrl && wr_data[B_STOP];
        upd_wr   = hit_ctrl && wr_data[B_UPDATE];
        clr_mask = hit_clr ? wr_data[ST_W-1:0] : '0;
    end

    // Hold the configuration registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_mode   <= 1'b0;
            te_en      <= 1'b0;
            te_pad_sel <= 1'b0;
            int_en     <= '0;
            shadow_cfg <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_MODE))    cmd_mode <= wr_data[B_CMD];
            if (wr_addr == ADDR_W'(A_TE_CTRL)) begin
                te_en      <= wr_data[B_TE_EN];
                te_pad_sel <= wr_data[B_TE_PAD];
            end
            if (wr_addr == ADDR_W'(A_INT_EN))  int_en <= wr_data[ST_W-1:0] & ST_VALID;
            if (wr_addr == ADDR_W'(A_SHADOW))  shadow_cfg <= wr_data[CFG_W-1:0];
        end
    end
endmodule

// File: rtl/disp_seq.sv
// Run/stop sequencer. It tracks the running and frame-busy state and
// moves the staged configuration into the active one. In video mode this
// happens at a frame end after an update request; in command mode it
// happens on start. It emits one-cycle event pulses. Assumes the mode is
// changed only while stopped.
module disp_seq
    import disp_ctrl_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_mode,
    input  logic             te_en,
    input  logic             te_pad_sel,
    input  logic             te_pad,
    input  logic             te_int,
    input  logic             frame_end,
    input  logic             start_wr,
    input  logic             stop_wr,
    input  logic             upd_wr,
    input  logic [CFG_W-1:0] shadow_cfg,
    output logic [CFG_W-1:0] active_cfg,
    output logic             running,
    output logic             frame_busy,
    output seq_evt_t         evt
);
    logic             running_q, busy_q, upd_pend_q, stop_pend_q, te_q;
    logic [CFG_W-1:0] active_q;
    logic             te_src, te_rise, run_start;

    // Select the tearing-effect source and find its enabled rising edge
    always_comb begin
        te_src    = te_pad_sel ? te_pad : te_int;
        te_rise   = te_en && te_src && !te_q;
        run_start = start_wr && !running_q;
    end

    // Form the event pulses from the present state and inputs
    always_comb begin
        evt.te    = te_rise;
        evt.vsync = running_q && !cmd_mode && frame_end;
        evt.upd   = running_q && !cmd_mode && frame_end && upd_pend_q;
        evt.done  = running_q && frame_end && (cmd_mode ? busy_q : stop_pend_q);
    end

    // Advance the run/stop state and commit the staged configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q   <= 1'b0;
            busy_q      <= 1'b0;
            upd_pend_q  <= 1'b0;
            stop_pend_q <= 1'b0;
            te_q        <= 1'b0;
            active_q    <= '0;
        end else begin
            te_q <= te_src;
            if (run_start) begin
                running_q   <= 1'b1;
                active_q    <= shadow_cfg;
                busy_q      <= 1'b0;
                upd_pend_q  <= 1'b0;
                stop_pend_q <= 1'b0;
            end else if (running_q && cmd_mode) begin
                if (!busy_q && te_rise) begin
                    busy_q <= 1'b1;
                end else if (busy_q && frame_end) begin
                    busy_q    <= 1'b0;
                    running_q <= 1'b0;
                end
            end else if (running_q) begin
                if (frame_end && upd_pend_q) begin
                    active_q   <= shadow_cfg;
                    upd_pend_q <= 1'b0;
                end
                if (frame_end && stop_pend_q) begin
                    running_q   <= 1'b0;
                    stop_pend_q <= 1'b0;
                end
                if (upd_wr)  upd_pend_q  <= 1'b1;
                if (stop_wr) stop_pend_q <= 1'b1;
            end else if (upd_wr && !cmd_mode) begin
                active_q <= shadow_cfg;
            end
        end
    end

    assign active_cfg = active_q;
    assign running    = running_q;
    assign frame_busy = busy_q;
endmodule

// File: rtl/disp_irq.sv
// Interrupt status register. Events set status bits whatever the enable
// mask holds, a write-one-to-clear mask clears them, and an event beats a
// clear of the same bit in the same cycle. The request is status AND
// enable, reduced by OR.
module disp_irq
    import disp_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  seq_evt_t        evt,
    input  logic            err_in,
    input  logic [ST_W-1:0] clr_mask,
    input  logic [ST_W-1:0] int_en,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] status_q;

    // Place each event on its status bit position
    always_comb begin
        set_vec           = '0;
        set_vec[EV_DONE]  = evt.done;
        set_vec[EV_TE]    = evt.te;
        set_vec[EV_ERR]   = err_in;
        set_vec[EV_UPD]   = evt.upd;
        set_vec[EV_VSYNC] = evt.vsync;
    end

    // Clear the masked bits, then set the new events
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q & ~clr_mask) | set_vec) & ST_VALID;
    end

    assign status = status_q;
    assign irq    = |(status_q & int_en);
endmodule

// File: rtl/disp_run_ctrl.sv
// Display run/stop and shadow-update controller, top level. It joins the
// register decoder, the run/stop sequencer and the interrupt status logic.
// Assumes all inputs are synchronous to clk.
module disp_run_ctrl
    import disp_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              frame_end,
    input  logic              te_int,
    input  logic              te_pad,
    input  logic              underflow,
    output logic [CFG_W-1:0]  active_cfg,
    output logic              running,
    output logic              frame_busy,
    output logic [7:0]        irq_status,
    output logic              irq
);
    logic             start_wr, stop_wr, upd_wr;
    logic [ST_W-1:0]  clr_mask, int_en;
    logic             cmd_mode, te_en, te_pad_sel;
    logic [CFG_W-1:0] shadow_cfg;
    seq_evt_t         evt;

    disp_reg_if #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_wr(start_wr), .stop_wr(stop_wr),
        .upd_wr(upd_wr), .clr_mask(clr_mask), .cmd_mode(cmd_mode),
        .te_en(te_en), .te_pad_sel(te_pad_sel), .int_en(int_en),
        .shadow_cfg(shadow_cfg)
    );

    disp_seq #(.CFG_W(CFG_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .cmd_mode(cmd_mode), .te_en(te_en),
        .te_pad_sel(te_pad_sel), .te_pad(te_pad), .te_int(te_int),
        .frame_end(frame_end), .start_wr(start_wr), .stop_wr(stop_wr),
        .upd_wr(upd_wr), .shadow_cfg(shadow_cfg), .active_cfg(active_cfg),
        .running(running), .frame_busy(frame_busy), .evt(evt)
    );

    disp_irq irq_i (
        .clk(clk), .rst_n(rst_n), .evt(evt), .err_in(underflow),
        .clr_mask(clr_mask), .int_en(int_en), .status(irq_status), .irq(irq)
    );
endmodule

// File: rtl/disp_run_ctrl_chk.sv
// Assertion checker for the display run/stop controller, bound to the top.
module disp_run_ctrl_chk
    import disp_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CFG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              frame_end,
    input logic              cmd_mode,
    input logic [CFG_W-1:0]  active_cfg,
    input logic              running,
    input logic              frame_busy,
    input logic [7:0]        irq_status,
    input logic              irq
);
    // R4
    stop_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(frame_end));

    // R3
    commit_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && (active_cfg != $past(active_cfg))) |-> $past(frame_end));

    // R8
    busy_in_cmd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_busy |-> (running && cmd_mode));

    // R11
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(irq_status) & ~irq_status)) |-> ($past(wr_en) && ($past(wr_addr) == ADDR_W'(A_INT_CLR))));

    // R5
    vsync_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[EV_VSYNC]) |-> ($past(frame_end) && $past(running)));

    // R10
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_status != 8'h00));
endmodule

bind disp_run_ctrl disp_run_ctrl_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .frame_end(frame_end), .cmd_mode(cmd_mode), .active_cfg(active_cfg),
    .running(running), .frame_busy(frame_busy), .irq_status(irq_status),
    .irq(irq)
);

// File: tb/disp_run_ctrl_tb_top.sv
`timescale 1ns/1ps
module disp_run_ctrl_tb_top;
    localparam logic [11:0] T_CTRL = 12'h004, T_MODE = 12'h008, T_SHADOW = 12'h030;
    localparam logic [11:0] T_EN = 12'h1E0, T_CLR = 12'h1E4, T_TE = 12'h1F0;

    logic        clk = 1'b0;
    logic        rst_n, wr_en, frame_end, te_int, te_pad, underflow;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic [15:0] active_cfg;
    logic        running, frame_busy, irq;
    logic [7:0]  irq_status;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    disp_run_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .te_int(te_int),
        .te_pad(te_pad), .underflow(underflow), .active_cfg(active_cfg),
        .running(running), .frame_busy(frame_busy), .irq_status(irq_status),
        .irq(irq)
    );

    function automatic logic [7:0] st_bits(input logic dn, input logic te,
                                           input logic er, input logic up,
                                           input logic vs);
        return {2'b00, vs, up, 1'b0, er, te, dn};
    endfunction

    function automatic logic exp_irq(input logic [7:0] st, input logic [7:0] en);
        return |(st & en);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic fe();
        frame_end = 1'b1;
        tick();
        frame_end = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] m_active;
        logic [7:0]  m_status;
        logic [31:0] rnd;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        frame_end = 1'b0; te_int = 1'b0; te_pad = 1'b0; underflow = 1'b0;
        rnd = $urandom(32'h5EED_1234);
        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 running", running, 0);
        check("R1 busy", frame_busy, 0);
        check("R1 active", active_cfg, 0);
        check("R1 status", irq_status, 0);
        check("R1 irq", irq, 0);

        // R2 start in video mode
        wr(T_SHADOW, 32'h1234);
        check("R2 not yet running", running, 0);
        wr(T_CTRL, 32'h1);
        check("R2 running", running, 1);
        check("R2 active loaded", active_cfg, 16'h1234);
        wr(T_SHADOW, 32'h9999);
        wr(T_CTRL, 32'h1);
        check("R2 start while running ignored", active_cfg, 16'h1234);

        // R3 deferred update
        wr(T_SHADOW, 32'hBEEF);
        check("R3 staged write no effect", active_cfg, 16'h1234);
        wr(T_CTRL, 32'h4);
        check("R3 held before frame end", active_cfg, 16'h1234);
        check("R3 no update-done yet", irq_status, 0);
        fe();
        check("R3 committed", active_cfg, 16'hBEEF);
        check("R3 R5 status", irq_status, st_bits(0, 0, 0, 1, 1));

        // R3 R5 random update/frame sequences
        m_active = 16'hBEEF;
        m_status = st_bits(0, 0, 0, 1, 1);
        for (int i = 0; i < 20; i++) begin
            logic [15:0] sh;
            logic        up;
            rnd = $urandom;
            sh  = rnd[15:0];
            up  = rnd[16];
            wr(T_SHADOW, {16'h0, sh});
            if (up) wr(T_CTRL, 32'h4);
            repeat (rnd[18:17]) tick();
            check("R3 random pre-frame", active_cfg, m_active);
            fe();
            if (up) m_active = sh;
            m_status = m_status | st_bits(0, 0, 0, up, 1);
            check("R3 random active", active_cfg, m_active);
            check("R5 random status", irq_status, m_status);
        end

        // R3 update written in the same cycle as a frame end
        wr(T_SHADOW, 32'h5555);
        frame_end = 1'b1;
        wr(T_CTRL, 32'h4);
        frame_end = 1'b0;
        check("R3 same-cycle not applied", active_cfg, m_active);
        fe();
        check("R3 applied next frame", active_cfg, 16'h5555);

        // R11 clear all, R10 enable and irq
        wr(T_CLR, 32'hFF);
        check("R11 clear all", irq_status, 0);
        check("R10 irq low", irq, 0);
        wr(T_EN, 32'h20);
        fe();
        check("R10 vsync status", irq_status, st_bits(0, 0, 0, 0, 1));
        check("R10 irq on enabled bit", irq, exp_irq(irq_status, 8'h20));
        frame_end = 1'b1;
        wr(T_CLR, 32'h20);
        frame_end = 1'b0;
        check("R11 event beats clear", irq_status, st_bits(0, 0, 0, 0, 1));
        wr(T_CLR, 32'h20);
        check("R11 masked clear", irq_status, 0);
        check("R10 irq cleared", irq, 0);
        underflow = 1'b1;
        tick();
        underflow = 1'b0;
        check("R10 underflow sets bit2", irq_status, st_bits(0, 0, 1, 0, 0));
        check("R10 disabled bit no irq", irq, 0);
        wr(T_EN, 32'h24);
        check("R10 irq after enable", irq, 1);
        wr(T_CLR, 32'hFF);
        wr(T_EN, 32'h0);

        // R4 stop in video mode
        wr(T_CTRL, 32'h2);
        check("R4 still running", running, 1);
        fe();
        check("R4 stopped", running, 0);
        check("R4 done status", irq_status, st_bits(1, 0, 0, 0, 1));

        // R6 update while stopped, R5 frame end while stopped
        wr(T_CLR, 32'hFF);
        wr(T_SHADOW, 32'h0A0A);
        wr(T_CTRL, 32'h4);
        check("R6 immediate copy", active_cfg, 16'h0A0A);
        check("R6 no status", irq_status, 0);
        fe();
        check("R5 no vsync when stopped", irq_status, 0);

        // R7 command mode start and ignored update
        wr(T_MODE, 32'h1);
        wr(T_TE, 32'h100);
        wr(T_SHADOW, 32'h7777);
        wr(T_CTRL, 32'h1);
        check("R7 active on start", active_cfg, 16'h7777);
        check("R7 running", running, 1);
        check("R8 not busy before TE", frame_busy, 0);
        wr(T_SHADOW, 32'h8888);
        wr(T_CTRL, 32'h4);
        check("R7 update ignored", active_cfg, 16'h7777);
        check("R7 no update-done", irq_status, 0);

        // R8 frame end before TE, then one frame
        fe();
        check("R8 early frame end running", running, 1);
        check("R8 early frame end status", irq_status, 0);
        te_int = 1'b1;
        tick();
        check("R8 busy after TE", frame_busy, 1);
        check("R8 TE status", irq_status, st_bits(0, 1, 0, 0, 0));
        te_int = 1'b0;
        tick();
        fe();
        check("R8 stopped after frame", running, 0);
        check("R8 busy cleared", frame_busy, 0);
        check("R8 done status", irq_status, st_bits(1, 1, 0, 0, 0));
        check("R7 active kept", active_cfg, 16'h7777);
        wr(T_CTRL, 32'h1);
        check("R7 second start loads", active_cfg, 16'h8888);

        // R9 TE disabled
        wr(T_CLR, 32'hFF);
        wr(T_TE, 32'h0);
        te_int = 1'b1;
        tick();
        te_int = 1'b0;
        tick();
        check("R9 no frame start", frame_busy, 0);
        check("R9 no TE status", irq_status, 0);

        // R8 pad source selection
        wr(T_TE, 32'h500);
        te_int = 1'b1;
        tick();
        te_int = 1'b0;
        tick();
        check("R8 internal TE unselected", frame_busy, 0);
        te_pad = 1'b1;
        tick();
        te_pad = 1'b0;
        check("R8 pad TE starts frame", frame_busy, 1);
        check("R8 pad TE status", irq_status, st_bits(0, 1, 0, 0, 0));
        fe();
        check("R8 pad frame done", running, 0);
        check("R8 pad done status", irq_status, st_bits(1, 1, 0, 0, 0));

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule